// File: doc/BRIEF.md
# Byte-Stream Packet Register Block

This block is a register slave that lets a host processor move network frames through a handful of word registers, one byte per bus access. To send a frame, the host writes the frame length to a transmit count register. It then writes the frame bytes one by one to a transmit data register. The bytes leave on a byte-wide valid/ready stream. Once the last byte has been taken by the stream sink, the count returns to zero and a transmit-done status bit is raised.

On the receive side, a frame source first offers the frame length over a small handshake. After that it delivers the bytes over a byte-wide valid/ready stream. The accepted length appears in a receive count register. Each read of the receive data register hands the next byte to the host and lowers the count by one. A receive-done status bit is set when a frame is announced. No further frame is accepted until the host clears that bit.

The block also has:
- a fixed 64-bit identification value;
- a read-only busy flag;
- a constant information word;
- an interrupt line, which is the OR of the status bits. One of those bits is a software test bit.

Both byte paths stage data in shallow FIFOs rather than frame-sized buffers.

Top module: `pktio_regs`

## Requirements
- R1: Word offset 0x00 reads the low half and 0x04 the high half of the 64-bit identification value "PKTSTRM1". The first character sits in bits 7:0 of offset 0x00, so the defaults read 0x53544B50 and 0x314D5254.
- R2: Read data appears on the read data port one cycle after the read strobe. Only address bits 5:2 are decoded. Offsets 0x24 to 0x3C read as zero.
- R3: A write to the transmit count (offset 0x10) is taken only when no transmit is pending and the value is in 1 to 65536. Otherwise it is ignored. While pending, the register reads back the programmed length.
- R4: Writes to the transmit data register (offset 0x20) forward bits 7:0 to the transmit stream, in write order. Writes beyond the programmed length are ignored. A byte held by the stream stays stable until it is taken.
- R5: When the last byte of a frame is taken by the transmit stream, the transmit count reads 0 and bit 0 of the status register (offset 0x14) is set.
- R6: A frame length is accepted only when:
  - the receive count is zero;
  - every byte of the previous frame has been delivered and read;
  - status bit 1 is clear.

  A length in 1 to 65536 loads the receive count (offset 0x0C) and sets status bit 1. Other lengths are dropped. Bytes are accepted only while the frame still owes bytes.
- R7: A read of the receive data register (offset 0x1C) returns the next received byte in bits 7:0 and decrements the receive count. A read when no byte is staged returns 0 and leaves the count unchanged.
- R8: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 1 to status bit 31 sets it and writing 0 clears it. The interrupt output is high exactly when any of the three bits is set.
- R9: Bit 0 of offset 0x08 reads 1 while the receive count or the transmit count is nonzero. Writes to the identification, busy, receive count and information offsets are ignored.
- R10: Offset 0x18 reads the constant information word, 0x00000007 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 6 | Byte address inside the 64-byte window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| irqOut | output | 1 | Interrupt, OR of the status bits |
| txByte | output | 8 | Transmit stream byte |
| txValid | output | 1 | Transmit byte available |
| txReady | input | 1 | Sink takes the transmit byte |
| rxLenValid | input | 1 | Frame length offered |
| rxLen | input | 17 | Offered frame length in bytes |
| rxLenReady | output | 1 | Block accepts a frame length |
| rxByte | input | 8 | Receive stream byte |
| rxByteValid | input | 1 | Receive byte offered |
| rxByteReady | output | 1 | Block accepts the receive byte |

## Verification
Transmit is tried in three ways: with the sink stalled, so bytes pile up; with the sink then drained; and with an over-long burst of writes. Together these separate correct ordering, the drop of surplus writes and the done event on the last handshake. Lengths of 0 and 65537, and a count rewrite during a pending frame, show whether the range and busy gates exist. On receive, a data read before any byte has arrived is tried, then full reads, and then a second frame offered while the done bit is still set. These tell a staged-byte pop from a blind count decrement and show whether the done bit really locks out new frames. The test bit, the read-only offsets and the unmapped offsets separate the write-clear from the write-set status semantics and show whether the address decode is complete.

// File: rtl/pktio_pkg.sv
package pktio_pkg;

  localparam logic [3:0] WORD_ID_LO  = 4'd0;
  localparam logic [3:0] WORD_ID_HI  = 4'd1;
  localparam logic [3:0] WORD_BUSY   = 4'd2;
  localparam logic [3:0] WORD_RXCNT  = 4'd3;
  localparam logic [3:0] WORD_TXCNT  = 4'd4;
  localparam logic [3:0] WORD_IRQ    = 4'd5;
  localparam logic [3:0] WORD_INFO   = 4'd6;
  localparam logic [3:0] WORD_RXDATA = 4'd7;
  localparam logic [3:0] WORD_TXDATA = 4'd8;

  localparam int IRQ_TX_BIT   = 0;
  localparam int IRQ_RX_BIT   = 1;
  localparam int IRQ_TEST_BIT = 31;

  typedef enum logic [3:0] {
    SEL_ID_LO,
    SEL_ID_HI,
    SEL_BUSY,
    SEL_RXCNT,
    SEL_TXCNT,
    SEL_IRQ,
    SEL_INFO,
    SEL_RXDATA,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    rdEn;
    regSel_e rdSel;
    logic    wrTxCount;
    logic    wrIrq;
    logic    wrTxData;
    logic    popRx;
  } ctrlStrobe_t;

endpackage

// File: rtl/pktio_fifo.sv
module pktio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill;

  logic doPush, doPop;
  assign empty    = (fill == '0);
  assign full     = (fill == DEPTH_C);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) begin
        store[wrPtr] <= pushData;
        wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/pktio_ctrl.sv
module pktio_ctrl
  import pktio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       stb
);
  logic [3:0] wordIdx;
  assign wordIdx = busAddr[5:2];

  always_comb begin
    stb           = '0;
    stb.rdSel     = SEL_NONE;
    stb.rdEn      = busRdEn;
    stb.wrTxCount = busWrEn && (wordIdx == WORD_TXCNT);
    stb.wrIrq     = busWrEn && (wordIdx == WORD_IRQ);
    stb.wrTxData  = busWrEn && (wordIdx == WORD_TXDATA);
    stb.popRx     = busRdEn && (wordIdx == WORD_RXDATA);
    case (wordIdx)
      WORD_ID_LO:  stb.rdSel = SEL_ID_LO;
      WORD_ID_HI:  stb.rdSel = SEL_ID_HI;
      WORD_BUSY:   stb.rdSel = SEL_BUSY;
      WORD_RXCNT:  stb.rdSel = SEL_RXCNT;
      WORD_TXCNT:  stb.rdSel = SEL_TXCNT;
      WORD_IRQ:    stb.rdSel = SEL_IRQ;
      WORD_INFO:   stb.rdSel = SEL_INFO;
      WORD_RXDATA: stb.rdSel = SEL_RXDATA;
      default:     stb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pktio_datapath.sv
module pktio_datapath
  import pktio_pkg::*;
#(
  parameter int          MAX_FRAME  = 65536,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [63:0] DEV_ID     = 64'h314D_5254_5354_4B50,
  parameter logic [31:0] INFO_WORD  = 32'h0000_0007,
  localparam int         CNT_W      = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             irqOut,
  output logic             busyFlag,
  output logic [7:0]       txByte,
  output logic             txValid,
  input  logic             txReady,
  input  logic             rxLenValid,
  input  logic [CNT_W-1:0] rxLen,
  output logic             rxLenReady,
  input  logic [7:0]       rxByte,
  input  logic             rxByteValid,
  output logic             rxByteReady
);
  localparam logic [31:0]      MAX_WORD = 32'(MAX_FRAME);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

  // transmit state
  logic [CNT_W-1:0] txCountQ, txAcceptLeft, txSendLeft;
  logic txEmpty, txFull, txPush, txPop, txLenOk, txDoneSet;
  // receive state
  logic [CNT_W-1:0] rxCountQ, rxInLeft;
  logic rxEmpty, rxFull, rxPush, rxPop, rxLenFire, rxLenOk;
  logic [7:0] rxHead;
  // status bits
  logic txDoneQ, rxDoneQ, testQ;

  // ---------------- transmit ----------------
  assign txLenOk   = (wrData != 32'd0) && (wrData <= MAX_WORD);
  assign txPush    = stb.wrTxData && (txAcceptLeft != '0) && !txFull;
  assign txValid   = !txEmpty;
  assign txPop     = txValid && txReady;
  assign txDoneSet = txPop && (txSendLeft == ONE_C);

  pktio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(txPush), .pushData(wrData[7:0]),
    .pop(txPop), .headData(txByte),
    .empty(txEmpty), .full(txFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCountQ     <= '0;
      txAcceptLeft <= '0;
      txSendLeft   <= '0;
    end else begin
      if (stb.wrTxCount && (txCountQ == '0) && txLenOk) begin
        txCountQ     <= wrData[CNT_W-1:0];
        txAcceptLeft <= wrData[CNT_W-1:0];
        txSendLeft   <= wrData[CNT_W-1:0];
      end else begin
        if (txPush) txAcceptLeft <= txAcceptLeft - 1'b1;
        if (txPop) begin
          txSendLeft <= txSendLeft - 1'b1;
          if (txDoneSet) txCountQ <= '0;
        end
      end
    end
  end

  // ---------------- receive ----------------
  assign rxLenReady  = (rxCountQ == '0) && (rxInLeft == '0) && !rxDoneQ && rxEmpty;
  assign rxLenFire   = rxLenValid && rxLenReady;
  assign rxLenOk     = (rxLen != '0) && ({{(32-CNT_W){1'b0}}, rxLen} <= MAX_WORD);
  assign rxByteReady = (rxInLeft != '0) && !rxFull;
  assign rxPush      = rxByteValid && rxByteReady;
  assign rxPop       = stb.popRx && !rxEmpty;

  pktio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxByte),
    .pop(rxPop), .headData(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCountQ <= '0;
      rxInLeft <= '0;
    end else begin
      if (rxLenFire && rxLenOk) begin
        rxCountQ <= rxLen;
        rxInLeft <= rxLen;
      end else begin
        if (rxPush) rxInLeft <= rxInLeft - 1'b1;
        if (rxPop)  rxCountQ <= rxCountQ - 1'b1;
      end
    end
  end

  // ---------------- status ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDoneQ <= 1'b0;
      rxDoneQ <= 1'b0;
      testQ   <= 1'b0;
    end else begin
      if (txDoneSet) txDoneQ <= 1'b1;
      else if (stb.wrIrq && wrData[IRQ_TX_BIT]) txDoneQ <= 1'b0;

      if (rxLenFire && rxLenOk) rxDoneQ <= 1'b1;
      else if (stb.wrIrq && wrData[IRQ_RX_BIT]) rxDoneQ <= 1'b0;

      if (stb.wrIrq) testQ <= wrData[IRQ_TEST_BIT];
    end
  end

  assign irqOut   = txDoneQ || rxDoneQ || testQ;
  assign busyFlag = (rxCountQ != '0) || (txCountQ != '0);

  // ---------------- read path ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_ID_LO:  rdData <= DEV_ID[31:0];
        SEL_ID_HI:  rdData <= DEV_ID[63:32];
        SEL_BUSY:   rdData <= {31'd0, busyFlag};
        SEL_RXCNT:  rdData <= 32'(rxCountQ);
        SEL_TXCNT:  rdData <= 32'(txCountQ);
        SEL_IRQ:    rdData <= {testQ, 29'd0, rxDoneQ, txDoneQ};
        SEL_INFO:   rdData <= INFO_WORD;
        SEL_RXDATA: rdData <= rxPop ? {24'd0, rxHead} : 32'd0;
        default:    rdData <= 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/pktio_regs.sv
module pktio_regs
  import pktio_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          MAX_FRAME  = 65536,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [63:0] DEV_ID     = 64'h314D_5254_5354_4B50,
  parameter logic [31:0] INFO_WORD  = 32'h0000_0007,
  localparam int         CNT_W      = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irqOut,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txReady,
  input  logic              rxLenValid,
  input  logic [CNT_W-1:0]  rxLen,
  output logic              rxLenReady,
  input  logic [7:0]        rxByte,
  input  logic              rxByteValid,
  output logic              rxByteReady
);
  ctrlStrobe_t stb;
  logic        busyFlag;

  pktio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .stb(stb)
  );

  pktio_datapath #(
    .MAX_FRAME(MAX_FRAME), .FIFO_DEPTH(FIFO_DEPTH),
    .DEV_ID(DEV_ID), .INFO_WORD(INFO_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .rdData(busRdData), .irqOut(irqOut), .busyFlag(busyFlag),
    .txByte(txByte), .txValid(txValid), .txReady(txReady),
    .rxLenValid(rxLenValid), .rxLen(rxLen), .rxLenReady(rxLenReady),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .rxByteReady(rxByteReady)
  );
endmodule

// File: rtl/pktio_regs_chk.sv
module pktio_regs_chk #(
  parameter int ADDR_W    = 6,
  parameter int MAX_FRAME = 65536,
  parameter int CNT_W     = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              irqOut,
  input logic [7:0]        txByte,
  input logic              txValid,
  input logic              txReady,
  input logic              rxLenValid,
  input logic [CNT_W-1:0]  rxLen,
  input logic              rxLenReady,
  input logic              rxByteReady,
  input logic              busyFlag
);
  localparam logic [ADDR_W-1:0] FIRST_HOLE = ADDR_W'(6'h24);
  localparam logic [ADDR_W-1:0] IRQ_ADDR   = ADDR_W'(6'h14);
  localparam logic [CNT_W-1:0]  MAX_LEN    = CNT_W'(MAX_FRAME);

  assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && (busAddr >= FIRST_HOLE) |=> busRdData == 32'd0);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));

  assert_tx_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busyFlag);

  assert_rx_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxLenValid && rxLenReady && (rxLen != '0) && (rxLen <= MAX_LEN) |=> !rxLenReady);

  assert_rx_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxByteReady |-> !rxLenReady);

  assert_test_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == IRQ_ADDR) && busWrData[31] |=> irqOut);
endmodule

bind pktio_regs pktio_regs_chk #(
  .ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .irqOut(irqOut), .txByte(txByte), .txValid(txValid), .txReady(txReady),
  .rxLenValid(rxLenValid), .rxLen(rxLen), .rxLenReady(rxLenReady),
  .rxByteReady(rxByteReady), .busyFlag(busyFlag)
);

// File: tb/sim_pktio_regs.sv
`timescale 1ns/1ps
module sim_pktio_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txReady = 1'b0;
  logic        rxLenValid = 1'b0;
  logic [16:0] rxLen = '0;
  logic        rxLenReady;
  logic [7:0]  rxByte = '0;
  logic        rxByteValid = 1'b0;
  logic        rxByteReady;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pktio_regs u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .txByte(txByte), .txValid(txValid), .txReady(txReady),
    .rxLenValid(rxLenValid), .rxLen(rxLen), .rxLenReady(rxLenReady),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .rxByteReady(rxByteReady)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R2 reset rdData", busRdData, 32'd0);
    check("R4 reset txValid", {31'd0, txValid}, 32'd0);
    check("R6 reset rxLenReady", {31'd0, rxLenReady}, 32'd1);
    check("R8 reset irq", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic testIdentity();
    logic [31:0] d;
    busRead(6'h00, d); check("R1 id low", d, 32'h5354_4B50);
    busRead(6'h04, d); check("R1 id high", d, 32'h314D_5254);
    busRead(6'h18, d); check("R10 info", d, 32'h0000_0007);
    busRead(6'h24, d); check("R2 hole 0x24", d, 32'd0);
    busRead(6'h3C, d); check("R2 hole 0x3C", d, 32'd0);
    busRead(6'h08, d); check("R9 idle busy", d, 32'd0);
    busWrite(6'h00, 32'hDEAD_BEEF);
    busWrite(6'h18, 32'h1234_5678);
    busWrite(6'h08, 32'h1);
    busRead(6'h00, d); check("R9 id write ignored", d, 32'h5354_4B50);
    busRead(6'h18, d); check("R9 info write ignored", d, 32'h0000_0007);
    busRead(6'h08, d); check("R9 busy write ignored", d, 32'd0);
  endtask

  task automatic testTxFrame();
    logic [31:0] d;
    logic [7:0] got [4];
    int n;
    txReady = 1'b0;
    busWrite(6'h10, 32'd3);
    busRead(6'h10, d); check("R3 tx count programmed", d, 32'd3);
    busWrite(6'h10, 32'd5);
    busRead(6'h10, d); check("R3 rewrite while pending ignored", d, 32'd3);
    busRead(6'h08, d); check("R9 busy during tx", d, 32'd1);
    busWrite(6'h20, 32'hFFFF_FFA1);
    check("R4 first byte visible", {23'd0, txValid, txByte}, {23'd0, 1'b1, 8'hA1});
    busWrite(6'h20, 32'h0000_01B2);
    busWrite(6'h20, 32'h0000_00C3);
    busWrite(6'h20, 32'h0000_00D4);
    check("R4 stalled byte holds", {24'd0, txByte}, 32'h0000_00A1);
    n = 0;
    @(negedge clk);
    txReady = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (txValid) begin
        if (n < 4) got[n] = txByte;
        n++;
      end
      @(negedge clk);
    end
    txReady = 1'b0;
    check("R4 byte count sent", n, 3);
    check("R4 byte 0", {24'd0, got[0]}, 32'hA1);
    check("R4 byte 1", {24'd0, got[1]}, 32'hB2);
    check("R4 byte 2", {24'd0, got[2]}, 32'hC3);
    busRead(6'h10, d); check("R5 tx count cleared", d, 32'd0);
    busRead(6'h14, d); check("R5 tx done bit", d, 32'h1);
    check("R8 irq on tx done", {31'd0, irqOut}, 32'd1);
    busRead(6'h08, d); check("R9 busy after tx", d, 32'd0);
    busWrite(6'h14, 32'h1);
    busRead(6'h14, d); check("R8 tx done cleared", d, 32'd0);
    check("R8 irq low", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic testTxBadLength();
    logic [31:0] d;
    busWrite(6'h10, 32'd0);
    busRead(6'h10, d); check("R3 length 0 rejected", d, 32'd0);
    busWrite(6'h10, 32'd65537);
    busRead(6'h10, d); check("R3 length 65537 rejected", d, 32'd0);
    busWrite(6'h20, 32'h55);
    check("R4 data without count ignored", {31'd0, txValid}, 32'd0);
    busWrite(6'h10, 32'd65536);
    busRead(6'h10, d); check("R3 length 65536 accepted", d, 32'd65536);
    busWrite(6'h20, 32'h77);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic offerLength(input logic [16:0] len, output logic taken);
    @(negedge clk);
    rxLenValid = 1'b1; rxLen = len;
    taken = rxLenReady;
    @(negedge clk);
    rxLenValid = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b, output logic taken);
    @(negedge clk);
    rxByteValid = 1'b1; rxByte = b;
    taken = rxByteReady;
    @(negedge clk);
    rxByteValid = 1'b0;
  endtask

  task automatic testRxFrame();
    logic [31:0] d;
    logic t;
    offerLength(17'd0, t);
    check("R6 zero length offered ready", {31'd0, t}, 32'd1);
    busRead(6'h0C, d); check("R6 zero length dropped", d, 32'd0);
    offerLength(17'd3, t);
    check("R6 length taken", {31'd0, t}, 32'd1);
    busRead(6'h0C, d); check("R6 rx count loaded", d, 32'd3);
    busRead(6'h14, d); check("R6 rx done bit", d, 32'h2);
    busWrite(6'h0C, 32'd99);
    busRead(6'h0C, d); check("R9 rx count write ignored", d, 32'd3);
    busRead(6'h1C, d); check("R7 read before data", d, 32'd0);
    busRead(6'h0C, d); check("R7 count kept on empty read", d, 32'd3);
    pushRx(8'h11, t); check("R6 byte 0 taken", {31'd0, t}, 32'd1);
    pushRx(8'h22, t); check("R6 byte 1 taken", {31'd0, t}, 32'd1);
    pushRx(8'h33, t); check("R6 byte 2 taken", {31'd0, t}, 32'd1);
    pushRx(8'h44, t); check("R6 surplus byte refused", {31'd0, t}, 32'd0);
    busRead(6'h1C, d); check("R7 rx byte 0", d, 32'h11);
    busRead(6'h0C, d); check("R7 count after 1", d, 32'd2);
    busRead(6'h1C, d); check("R7 rx byte 1", d, 32'h22);
    busRead(6'h1C, d); check("R7 rx byte 2", d, 32'h33);
    busRead(6'h0C, d); check("R7 count drained", d, 32'd0);
    busRead(6'h1C, d); check("R7 read past end", d, 32'd0);
    offerLength(17'd2, t);
    check("R6 blocked while done set", {31'd0, t}, 32'd0);
    busRead(6'h0C, d); check("R6 count untouched", d, 32'd0);
    busWrite(6'h14, 32'h2);
    check("R8 rx done cleared", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R6 ready after clear", {31'd0, rxLenReady}, 32'd1);
  endtask

  task automatic testTestBit();
    logic [31:0] d;
    busWrite(6'h14, 32'h8000_0000);
    check("R8 test bit raises irq", {31'd0, irqOut}, 32'd1);
    busRead(6'h14, d); check("R8 test bit reads", d, 32'h8000_0000);
    busWrite(6'h14, 32'h0);
    check("R8 test bit cleared by zero", {31'd0, irqOut}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdentity();
    testTxFrame();
    testTxBadLength();
    testRxFrame();
    testTestBit();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule